// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block sits on the host side of a byte-wide parallel EEPROM. It takes requests on a valid/ready interface. A write request carries a start address, a byte count and up to one page of data. A read request carries one address. The block turns each request into the pin activity the memory needs: chip enable, output enable, write enable, address and data. Every pulse width and spacing is derived from nanosecond parameters and the clock period.

A page write loads every byte as its own write-enable pulse. The loads follow one another fast enough that the device still treats them as one page. After the last load, the sequencer reads the last written address again and again. The write is complete once bit 7 of the read data matches bit 7 of the last byte written. If that match does not come within the maximum write time, the request ends with a timeout error.

The block rejects requests that cannot be served. These are write requests that would run past the end of a page, write requests with a zero byte count, and any request that arrives while a completion poll is running.

Top module: `eep_page_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, chip enable, output enable and write enable are all high (inactive), the data driver is off and no response pulse is raised.
- R2: Every write-enable low pulse lasts at least ceil(WE_NS/CLK_NS) cycles. Address and write data stay stable for the whole pulse.
- R3: Successive write-enable falls within one page write are at least ceil(GAP_NS/CLK_NS) cycles apart and at most ceil(WIN_NS/CLK_NS) cycles apart.
- R4: Output enable is high whenever write enable is low. The data driver is enabled only while output enable is high.
- R5: A write of N bytes at address A programs addresses A to A+N-1 in increasing order. Byte k comes from req_data bits [8k+7:8k]. No other address is written.
- R6: A write request whose byte count is 0 is rejected, and so is one whose in-page offset (the low log2(PAGE_BYTES) address bits) plus the byte count exceeds PAGE_BYTES. A rejection is a one-cycle req_reject pulse in the cycle after the request is accepted. A rejected request produces no write-enable pulse and changes no memory location.
- R7: After the last load, the sequencer reads the last address with output enable low. It samples read data no earlier than ceil(ACC_NS/CLK_NS) cycles after output enable falls. It raises output enable for one cycle between polls. The first sample whose bit 7 equals bit 7 of the last byte gives a one-cycle done_valid with done_err = 0.
- R8: If no poll matches within ceil(TMAX_NS/CLK_NS) polling cycles, the sequencer ends the write with done_valid and done_err = 1. That pulse comes HI+TMAX cycles after the last write-enable rise, where HI is the write-enable high time between loads.
- R9: A request presented while a poll is running is accepted and rejected with req_reject. It does not disturb the poll in progress.
- R10: A read request gives a one-cycle rd_valid with rd_data equal to the memory byte at the requested address. The byte is sampled no earlier than the access time after output enable falls.
- R11: req_ready is high when the block is idle or polling, and low during byte loads and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = page write, 0 = single byte read |
| req_addr | input | AW | Start address of the request |
| req_nbytes | input | NW | Bytes to write, 1 to PAGE_BYTES |
| req_data | input | PAGE_BYTES*8 | Write bytes, byte k in bits [8k+7:8k] |
| req_reject | output | 1 | One-cycle pulse: request refused |
| done_valid | output | 1 | One-cycle pulse: page write finished |
| done_err | output | 1 | With done_valid: 1 = timeout |
| rd_valid | output | 1 | One-cycle pulse: read data ready |
| rd_data | output | 8 | Read data |
| ee_ce_n | output | 1 | Memory chip enable, active low |
| ee_oe_n | output | 1 | Memory output enable, active low |
| ee_we_n | output | 1 | Memory write enable, active low |
| ee_addr | output | AW | Memory address |
| ee_dout | output | 8 | Data driven to the memory |
| ee_dout_en | output | 1 | Drive enable for ee_dout |
| ee_din | input | 8 | Data read from the memory |

## Verification
The bench sweeps every in-page offset and byte count on a four-byte page. It reads each page back through the block itself, so a sequencer that skips a byte, swaps the byte order or spills into a neighbour shows up as wrong read data. The memory model returns bit 7 inverted while it is busy, and returns garbage until the access time has passed. A sequencer that samples one cycle early either finishes before the write is done or returns corrupt read data. Requests that cross a page boundary, requests with a zero byte count and requests made during a poll must give a reject pulse and leave memory untouched. A memory that never finishes must give a timeout at the exact cycle count, so a timer that is off by a window or never expires is caught.

// File: rtl/eep_seq_pkg.sv
package eep_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WLOW, S_WHI, S_PACC, S_PGAP, S_RACC
  } seq_st_e;

  // nanoseconds to cycles, rounded up, never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  // high time after a write pulse so that setup + low + high reaches the load spacing
  function automatic int unsigned hi_cyc(input int unsigned gap, input int unsigned low);
    return (gap > low + 2) ? gap - low - 1 : 1;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/eep_page_guard.sv
module eep_page_guard #(
  parameter int PAGE_BYTES = 64,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int NW = $clog2(PAGE_BYTES + 1)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [NW-1:0]    nbytes,
  output logic             fits
);
  localparam int SW = NW + 1;
  logic [SW-1:0] span_end;

  assign span_end = SW'(offset) + SW'(nbytes);
  assign fits = (nbytes != '0) && (span_end <= SW'(PAGE_BYTES));
endmodule

// File: rtl/eep_byte_mux.sv
module eep_byte_mux #(
  parameter int PAGE_BYTES = 64,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic [PAGE_BYTES*8-1:0] page_data,
  input  logic [OFF_W-1:0]        sel,
  output logic [7:0]              byte_out
);
  logic [7:0] lane [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    assign lane[g] = page_data[g*8 +: 8];
  end

  assign byte_out = lane[sel];
endmodule

// File: rtl/eep_poll_timer.sv
module eep_poll_timer #(
  parameter int unsigned LIMIT = 1000,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  logic [TW-1:0] ticks;

  always_ff @(posedge clk) begin
    if (rst || clr) ticks <= '0;
    else if (run)   ticks <= ticks + 1'b1;
  end

  assign expired = run && (ticks == TW'(LIMIT - 1));
endmodule

// File: rtl/eep_page_seq.sv
module eep_page_seq
  import eep_seq_pkg::*;
#(
  parameter int AW = 15,
  parameter int PAGE_BYTES = 64,
  parameter int unsigned CLK_NS = 5,
  parameter int unsigned WE_NS = 150,
  parameter int unsigned GAP_NS = 200,
  parameter int unsigned WIN_NS = 149000,
  parameter int unsigned ACC_NS = 120,
  parameter int unsigned TMAX_NS = 10000000,
  localparam int NW = $clog2(PAGE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [NW-1:0]           req_nbytes,
  input  logic [PAGE_BYTES*8-1:0] req_data,
  output logic                    req_reject,
  output logic                    done_valid,
  output logic                    done_err,
  output logic                    rd_valid,
  output logic [7:0]              rd_data,
  output logic                    ee_ce_n,
  output logic                    ee_oe_n,
  output logic                    ee_we_n,
  output logic [AW-1:0]           ee_addr,
  output logic [7:0]              ee_dout,
  output logic                    ee_dout_en,
  input  logic [7:0]              ee_din
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int unsigned WE_CYC  = ns2cyc(WE_NS, CLK_NS);
  localparam int unsigned GAP_CYC = ns2cyc(GAP_NS, CLK_NS);
  localparam int unsigned HI_CYC  = hi_cyc(GAP_CYC, WE_CYC);
  localparam int unsigned ACC_CYC = ns2cyc(ACC_NS, CLK_NS);
  localparam int unsigned TMO_CYC = ns2cyc(TMAX_NS, CLK_NS);
  localparam int CW = $clog2(max3(WE_CYC, HI_CYC, ACC_CYC) + 1);

  seq_st_e st;
  logic [CW-1:0] cnt;
  logic [OFF_W-1:0] idx;
  logic [AW-1:0] base_q;
  logic [NW-1:0] nb_q;
  logic [PAGE_BYTES*8-1:0] data_q;

  // named events, also watched by the checker
  logic page_ok, cur_last, acc_done, samp_evt, poll_match, poll_start, tmo_hit, busy_rej;
  logic polling;
  logic [7:0] cur_byte;

  eep_page_guard #(.PAGE_BYTES(PAGE_BYTES)) guard_i (
    .offset(req_addr[OFF_W-1:0]), .nbytes(req_nbytes), .fits(page_ok));

  eep_byte_mux #(.PAGE_BYTES(PAGE_BYTES)) mux_i (
    .page_data(data_q), .sel(idx), .byte_out(cur_byte));

  eep_poll_timer #(.LIMIT(TMO_CYC)) tmr_i (
    .clk(clk), .rst(rst), .clr(poll_start), .run(polling), .expired(tmo_hit));

  assign polling    = (st == S_PACC) || (st == S_PGAP);
  assign cur_last   = (NW'(idx) + NW'(1)) == nb_q;
  assign acc_done   = cnt == CW'(ACC_CYC - 1);
  assign samp_evt   = ((st == S_PACC) || (st == S_RACC)) && acc_done;
  assign poll_match = (st == S_PACC) && samp_evt && (ee_din[7] == cur_byte[7]);
  assign poll_start = (st == S_WHI) && (cnt == CW'(HI_CYC - 1)) && cur_last;
  assign busy_rej   = polling && req_valid;
  assign req_ready  = (st == S_IDLE) || polling;

  assign ee_addr = base_q + AW'(idx);
  assign ee_dout = cur_byte;

  always_comb begin
    ee_ce_n = 1'b1;
    ee_oe_n = 1'b1;
    ee_we_n = 1'b1;
    ee_dout_en = 1'b0;
    unique case (st)
      S_WSET, S_WHI: begin ee_ce_n = 1'b0; ee_dout_en = 1'b1; end
      S_WLOW:        begin ee_ce_n = 1'b0; ee_we_n = 1'b0; ee_dout_en = 1'b1; end
      S_PACC, S_RACC: begin ee_ce_n = 1'b0; ee_oe_n = 1'b0; end
      S_PGAP:        ee_ce_n = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      base_q <= '0;
      nb_q <= '0;
      data_q <= '0;
      req_reject <= 1'b0;
      done_valid <= 1'b0;
      done_err <= 1'b0;
      rd_valid <= 1'b0;
      rd_data <= '0;
    end else begin
      req_reject <= busy_rej;
      done_valid <= 1'b0;
      rd_valid <= 1'b0;
      cnt <= cnt + 1'b1;
      unique case (st)
        S_IDLE: begin
          cnt <= '0;
          if (req_valid) begin
            if (!req_write) begin
              base_q <= req_addr;
              idx <= '0;
              st <= S_RACC;
            end else if (page_ok) begin
              base_q <= req_addr;
              nb_q <= req_nbytes;
              data_q <= req_data;
              idx <= '0;
              st <= S_WSET;
            end else begin
              req_reject <= 1'b1;
            end
          end
        end
        S_WSET: begin cnt <= '0; st <= S_WLOW; end
        S_WLOW: if (cnt == CW'(WE_CYC - 1)) begin cnt <= '0; st <= S_WHI; end
        S_WHI: if (cnt == CW'(HI_CYC - 1)) begin
          cnt <= '0;
          if (cur_last) st <= S_PACC;
          else begin idx <= idx + 1'b1; st <= S_WSET; end
        end
        S_PACC: begin
          if (poll_match) begin
            done_valid <= 1'b1; done_err <= 1'b0; st <= S_IDLE;
          end else if (tmo_hit) begin
            done_valid <= 1'b1; done_err <= 1'b1; st <= S_IDLE;
          end else if (samp_evt) begin
            st <= S_PGAP;
          end
        end
        S_PGAP: begin
          cnt <= '0;
          if (tmo_hit) begin
            done_valid <= 1'b1; done_err <= 1'b1; st <= S_IDLE;
          end else st <= S_PACC;
        end
        S_RACC: if (acc_done) begin
          rd_valid <= 1'b1; rd_data <= ee_din; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eep_seq_chk.sv
module eep_seq_chk
  import eep_seq_pkg::*;
#(
  parameter int AW = 15,
  parameter int unsigned CLK_NS = 5,
  parameter int unsigned WE_NS = 150,
  parameter int unsigned GAP_NS = 200,
  parameter int unsigned ACC_NS = 120
) (
  input logic          clk,
  input logic          rst,
  input logic          ee_ce_n,
  input logic          ee_oe_n,
  input logic          ee_we_n,
  input logic          ee_dout_en,
  input logic [AW-1:0] ee_addr,
  input logic [7:0]    ee_dout,
  input logic          samp_evt,
  input logic          done_valid,
  input logic          rd_valid,
  input logic          req_reject
);
  localparam int unsigned WE_CYC  = ns2cyc(WE_NS, CLK_NS);
  localparam int unsigned GAP_CYC = ns2cyc(GAP_NS, CLK_NS);
  localparam int unsigned ACC_CYC = ns2cyc(ACC_NS, CLK_NS);
  localparam int KW = $clog2(max3(WE_CYC, GAP_CYC, ACC_CYC) + 2);

  logic we_q;
  logic [KW-1:0] low_cnt, gap_cnt, oe_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b1;
      low_cnt <= '0;
      gap_cnt <= KW'(GAP_CYC);
      oe_cnt <= '0;
    end else begin
      we_q <= ee_we_n;
      if (ee_we_n) low_cnt <= '0;
      else if (low_cnt < KW'(WE_CYC)) low_cnt <= low_cnt + 1'b1;
      if (we_q && !ee_we_n) gap_cnt <= KW'(1);
      else if (gap_cnt < KW'(GAP_CYC)) gap_cnt <= gap_cnt + 1'b1;
      if (ee_oe_n) oe_cnt <= '0;
      else if (oe_cnt < KW'(ACC_CYC)) oe_cnt <= oe_cnt + 1'b1;
    end
  end

  // R1
  p_idle_pins_r1: assert property (@(posedge clk)
    rst |=> (ee_ce_n && ee_oe_n && ee_we_n && !ee_dout_en && !done_valid && !rd_valid && !req_reject))
    else $error("p_idle_pins_r1");

  // R2
  p_we_width_r2: assert property (@(posedge clk) disable iff (rst)
    (ee_we_n && !we_q) |-> (low_cnt >= KW'(WE_CYC)))
    else $error("p_we_width_r2");

  // R2
  p_we_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!ee_we_n && !we_q) |-> ($stable(ee_addr) && $stable(ee_dout)))
    else $error("p_we_stable_r2");

  // R3
  p_load_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (we_q && !ee_we_n) |-> (gap_cnt >= KW'(GAP_CYC)))
    else $error("p_load_gap_r3");

  // R4
  p_oe_off_r4: assert property (@(posedge clk) disable iff (rst)
    !ee_we_n |-> ee_oe_n)
    else $error("p_oe_off_r4");

  // R4
  p_drive_r4: assert property (@(posedge clk) disable iff (rst)
    ee_dout_en |-> (ee_oe_n && !ee_ce_n))
    else $error("p_drive_r4");

  // R7
  p_sample_late_r7: assert property (@(posedge clk) disable iff (rst)
    samp_evt |-> (!ee_oe_n && (oe_cnt + KW'(1) >= KW'(ACC_CYC))))
    else $error("p_sample_late_r7");

  // R7
  p_resp_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_valid, rd_valid}))
    else $error("p_resp_excl_r7");
endmodule

bind eep_page_seq eep_seq_chk #(
  .AW(AW), .CLK_NS(CLK_NS), .WE_NS(WE_NS), .GAP_NS(GAP_NS), .ACC_NS(ACC_NS)
) chk_i (
  .clk(clk), .rst(rst), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n),
  .ee_dout_en(ee_dout_en), .ee_addr(ee_addr), .ee_dout(ee_dout), .samp_evt(samp_evt),
  .done_valid(done_valid), .rd_valid(rd_valid), .req_reject(req_reject)
);

// File: tb/eep_page_seq_tb_top.sv
module eep_page_seq_tb_top;
  localparam int AW = 6;
  localparam int PB = 4;
  localparam int NW = 3;
  localparam int WE_C = 30;    // 150 ns / 5 ns
  localparam int GAP_C = 40;   // 200 ns / 5 ns
  localparam int HI_C = 9;     // 40 - 30 - 1
  localparam int ACC_C = 24;   // 120 ns / 5 ns
  localparam int LIM_C = 1000; // 5000 ns / 5 ns
  localparam int WIN_C = 29800;
  localparam int BUSY_C = 150;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [NW-1:0] req_nbytes = '0;
  logic [PB*8-1:0] req_data = '0;
  logic req_ready, req_reject, done_valid, done_err, rd_valid;
  logic [7:0] rd_data;
  logic ee_ce_n, ee_oe_n, ee_we_n, ee_dout_en;
  logic [AW-1:0] ee_addr;
  logic [7:0] ee_dout, ee_din;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #2.5 clk = ~clk;

  eep_page_seq #(.AW(AW), .PAGE_BYTES(PB), .CLK_NS(5), .WE_NS(150), .GAP_NS(200),
                 .WIN_NS(149000), .ACC_NS(120), .TMAX_NS(5000)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_nbytes(req_nbytes), .req_data(req_data), .req_reject(req_reject),
    .done_valid(done_valid), .done_err(done_err), .rd_valid(rd_valid), .rd_data(rd_data),
    .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n), .ee_addr(ee_addr),
    .ee_dout(ee_dout), .ee_dout_en(ee_dout_en), .ee_din(ee_din));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem [64];
  logic [7:0] shadow [64];
  int busy = 0, oe_cnt = 0, n_loads = 0;
  bit stuck = 0, last_b7 = 0, we_q = 1;
  int low_cnt = 0, last_fall = -1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    we_q <= ee_we_n;
    oe_cnt <= ee_oe_n ? 0 : oe_cnt + 1;
    if (!rst && !we_q && ee_we_n && !ee_ce_n) begin
      mem[ee_addr] <= ee_dout;
      last_b7 <= ee_dout[7];
      busy <= BUSY_C;
      n_loads <= n_loads + 1;
    end else if (busy > 0 && !stuck) busy <= busy - 1;
  end

  always_comb begin
    if (ee_ce_n || ee_oe_n || oe_cnt < ACC_C - 1) ee_din = {~last_b7, 7'h25};
    else if (busy > 0) ee_din = {~last_b7, 7'h2A};
    else ee_din = mem[ee_addr];
  end

  // ---------------- pin timing monitor ----------------
  logic [AW-1:0] a_hold;
  logic [7:0] d_hold;
  always @(negedge clk) begin
    if (!rst) begin
      if (!ee_we_n) begin
        chk(ee_oe_n, "R4 oe low during write pulse", ee_oe_n, 1);
        if (low_cnt == 0) begin
          a_hold = ee_addr; d_hold = ee_dout;
          if (last_fall >= 0) begin
            chk(cyc - last_fall >= GAP_C, "R3 load spacing min", cyc - last_fall, GAP_C);
            chk(cyc - last_fall <= WIN_C, "R3 load spacing max", cyc - last_fall, WIN_C);
          end
          last_fall = cyc;
        end else if (ee_addr != a_hold || ee_dout != d_hold)
          chk(0, "R2 addr/data moved in pulse", {ee_addr, ee_dout}, {a_hold, d_hold});
        low_cnt++;
      end else begin
        if (low_cnt > 0) chk(low_cnt >= WE_C, "R2 we low width", low_cnt, WE_C);
        low_cnt = 0;
      end
      if (ee_dout_en) chk(ee_oe_n, "R4 driver with oe low", ee_oe_n, 1);
      if (done_valid) last_fall = -1;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [7:0] pat(input int p, input int o, input int k);
    return 8'((p * 37 + o * 11 + k * 73 + 5) ^ 150);
  endfunction

  int we_rise_cyc = 0;
  always @(negedge clk) if (ee_we_n && !we_q) we_rise_cyc = cyc;

  task automatic send(input bit wr, input int addr, input int n, input logic [PB*8-1:0] d,
                      output bit rej);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(addr); req_nbytes = NW'(n); req_data = d;
    @(negedge clk);
    rej = req_reject;
    req_valid = 0;
  endtask

  task automatic wait_done(output bit err, output int at);
    err = 1; at = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done_valid) begin err = done_err; at = cyc; return; end
      @(negedge clk);
    end
    chk(0, "R7 done never seen", 0, 1);
  endtask

  task automatic rd(input int addr, output logic [7:0] v);
    bit rj;
    send(0, addr, 0, '0, rj);
    v = 8'hxx;
    for (int i = 0; i < 100; i++) begin
      if (rd_valid) begin v = rd_data; return; end
      @(negedge clk);
    end
    chk(0, "R10 rd_valid never seen", 0, 1);
  endtask

  task automatic check_page(input int page, input string tag);
    logic [7:0] v;
    for (int i = 0; i < PB; i++) begin
      rd(page * PB + i, v);
      chk(v === shadow[page * PB + i], tag, v, shadow[page * PB + i]);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    wait (cyc > 150000);
    chk(0, "watchdog expired", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    bit rj, er;
    int at, loads0;
    logic [PB*8-1:0] d;
    for (int i = 0; i < 64; i++) begin mem[i] = 8'(i * 5 + 3); shadow[i] = 8'(i * 5 + 3); end
    repeat (4) @(negedge clk);
    chk(ee_ce_n && ee_oe_n && ee_we_n && !ee_dout_en, "R1 pins idle in reset",
        {ee_ce_n, ee_oe_n, ee_we_n, ee_dout_en}, 4'b1110);
    rst = 0;
    @(negedge clk);
    chk(!done_valid && !rd_valid && !req_reject, "R1 no pulses after reset",
        {done_valid, rd_valid, req_reject}, 0);
    chk(req_ready, "R11 ready when idle", req_ready, 1);

    // R5 R7 R10: every offset and count that fits a page
    for (int o = 0; o < PB; o++) begin
      for (int n = 1; n <= PB - o; n++) begin
        int page = (o * 4 + n) % 16;
        for (int k = 0; k < PB; k++) d[k*8 +: 8] = pat(page, o, k);
        send(1, page * PB + o, n, d, rj);
        chk(!rj, "R6 fitting write not rejected", rj, 0);
        if (o == 0 && n == PB) begin
          repeat (5) @(negedge clk);
          chk(!req_ready, "R11 ready low while loading", req_ready, 0);
        end
        wait_done(er, at);
        chk(!er, "R7 write completes without error", er, 0);
        for (int k = 0; k < n; k++) shadow[page * PB + o + k] = pat(page, o, k);
        check_page(page, "R5 page contents after write");
      end
    end

    // R6: page-crossing and zero-count writes
    for (int o = 0; o < PB; o++) begin
      for (int n = 0; n <= PB; n++) begin
        if (n != 0 && o + n <= PB) continue;
        loads0 = n_loads;
        send(1, 9 * PB + o, n, 32'hDEADBEEF, rj);
        chk(rj, "R6 reject pulse", rj, 1);
        repeat (3) @(negedge clk);
        chk(n_loads == loads0, "R6 no write pulse", n_loads, loads0);
      end
    end
    check_page(9, "R6 memory untouched");

    // R9: request during polling
    d = 32'h11223344;
    send(1, 3 * PB, PB, d, rj);
    wait (!ee_oe_n);
    @(negedge clk);
    chk(req_ready, "R11 ready while polling", req_ready, 1);
    loads0 = n_loads;
    send(1, 12 * PB, 2, 32'hA5A5A5A5, rj);
    chk(rj, "R9 busy reject", rj, 1);
    wait_done(er, at);
    chk(!er && n_loads == loads0, "R9 poll unaffected", {er, 8'(n_loads - loads0)}, 0);
    for (int k = 0; k < PB; k++) shadow[3 * PB + k] = d[k*8 +: 8];
    check_page(3, "R9 target page");
    check_page(12, "R9 rejected page untouched");

    // R8: device never finishes
    stuck = 1;
    send(1, 5 * PB + 1, 2, 32'h0000_7F80, rj);
    wait_done(er, at);
    chk(er, "R8 timeout flagged", er, 1);
    chk(at - we_rise_cyc >= HI_C + LIM_C - 1 && at - we_rise_cyc <= HI_C + LIM_C + 1,
        "R8 timeout delay", at - we_rise_cyc, HI_C + LIM_C);
    stuck = 0;
    busy = 0;
    shadow[5 * PB + 1] = 8'h80; shadow[5 * PB + 2] = 8'h7F;
    check_page(5, "R10 read after timeout");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule